// File: doc/BRIEF.md
# Downstream Memory Read Command Translator and Splitter

This block sits between the downstream request path of a PCIe-to-PCI bridge and a PCI master. It accepts memory read request descriptors (DWord-aligned address, length in DWords, first and last DWord byte enables, tag). For each one it picks the PCI read command from two address windows and the cacheline size. It then issues PCI read attempts, one at a time, to the master. Each completed piece of data is reported as a completion fragment descriptor that never spans a 128-byte address boundary.

Up to `NSLOT` requests are tracked at once. Each slot holds its own tag, command, next DWord address, remaining length and fragment accumulator. When the master reports a retry or a disconnect, the next attempt rotates to another slot with work pending, so a stalled target does not hold up the other requests. A request whose byte range lies in neither window is reported as unsupported and never reaches the PCI side.

Top module: `rdx_rd_split`

## Requirements
- R1: A request whose whole byte range lies inside the inclusive non-prefetchable window (`np_base`..`np_limit`) is issued with command 4'b0110. This window is checked before the prefetchable one.
- R2: A request inside the inclusive prefetchable window whose length in DWords is less than or equal to `cls_dw` is issued with command 4'b1110. Equality selects this command.
- R3: A request inside the prefetchable window whose length in DWords exceeds `cls_dw` is issued with command 4'b1100.
- R4: A request whose range is not fully inside either window raises `ur_valid` with its tag for one cycle, in the cycle after acceptance. It occupies no slot and produces no PCI attempt.
- R5: An attempt's DWord length is the smaller of the remaining request length and the DWords left before the next 128-byte address boundary, so no attempt crosses such a boundary.
- R6: The attempts of a request cover exactly its DWords, in ascending address order. Nothing past the requested length is ever read.
- R7: `pci_be_first` carries `req_fbe` on the request's first DWord and `pci_be_last` carries `req_lbe` on its last DWord; all other DWords use 4'hF. A one-DWord request carries `req_fbe` in both fields. In a one-DWord attempt, both fields carry the same value.
- R8: Status kind 2'd1 (retry) moves nothing forward. Kind 2'd2 (disconnect after `st_dw` DWords) advances the next attempt's address by 4*`st_dw` and shrinks its length by `st_dw`, and leaves the command unchanged. Neither kind raises `cpl_valid`.
- R9: Status kind 2'd0 (done) raises `cpl_valid` for one cycle after the status edge. It reports the fragment's start byte address, the DWords gathered since that start (including any disconnected parts), and `cpl_last` when the request is finished.
- R10: Up to `NSLOT` requests are outstanding, and `req_ready` is low while all slots are busy. After each status, the next attempt goes to the next busy slot in circular ascending order after the slot that was just served.
- R11: After reset `pci_valid`, `cpl_valid` and `ur_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request descriptor present |
| req_ready | output | 1 | A slot is free; request taken on valid and ready |
| req_addr | input | AW | Request byte address (bits 1:0 ignored) |
| req_len | input | LW | Request length in DWords (1..1024) |
| req_fbe | input | 4 | First DWord byte enables |
| req_lbe | input | 4 | Last DWord byte enables |
| req_tag | input | TW | Request tag |
| np_base | input | AW | Non-prefetchable window base byte address |
| np_limit | input | AW | Non-prefetchable window last byte address |
| pf_base | input | AW | Prefetchable window base byte address |
| pf_limit | input | AW | Prefetchable window last byte address |
| cls_dw | input | CW | Cacheline size in DWords |
| pci_valid | output | 1 | PCI read attempt outstanding; fields stable |
| pci_cmd | output | 4 | PCI read command |
| pci_addr | output | AW | Attempt start byte address |
| pci_len | output | LW | Attempt length in DWords |
| pci_be_first | output | 4 | Byte enables of the attempt's first DWord |
| pci_be_last | output | 4 | Byte enables of the attempt's last DWord |
| pci_tag | output | TW | Tag of the request the attempt serves |
| st_valid | input | 1 | Attempt status strobe |
| st_kind | input | 2 | 0 done, 1 retry, 2 disconnect |
| st_dw | input | LW | DWords moved before a disconnect |
| cpl_valid | output | 1 | Completion fragment descriptor strobe |
| cpl_tag | output | TW | Fragment tag |
| cpl_addr | output | AW | Fragment start byte address |
| cpl_len | output | LW | Fragment length in DWords |
| cpl_last | output | 1 | Final fragment of the request |
| ur_valid | output | 1 | Unsupported request strobe |
| ur_tag | output | TW | Tag of the unsupported request |

## Verification
The assertions assume the master behaves. It raises `st_valid` only while `pci_valid` is high, and it reports a disconnect with a count smaller than the attempt length. They also assume requests have a nonzero length of at most 1024 DWords and that each window's base does not exceed its limit. The stimulus drives one status per attempt, at most one cycle long, and only after it has seen the attempt. Disconnect counts stay below the attempt length, lengths stay small, and the windows are programmed once before any request.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

  typedef enum logic [3:0] {
    CMD_MR  = 4'b0110,
    CMD_MRL = 4'b1110,
    CMD_MRM = 4'b1100
  } rd_cmd_e;

  typedef enum logic [1:0] {
    ST_DONE  = 2'd0,
    ST_RETRY = 2'd1,
    ST_DISC  = 2'd2
  } att_status_e;

endpackage

// File: rtl/rdx_classify.sv
module rdx_classify
  import rdx_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 11,
  parameter int CW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len_dw,
  input  logic [AW-1:0] np_base,
  input  logic [AW-1:0] np_limit,
  input  logic [AW-1:0] pf_base,
  input  logic [AW-1:0] pf_limit,
  input  logic [CW-1:0] cls_dw,
  output logic          hit,
  output logic [3:0]    cmd
);
  localparam int EW = AW + 1;

  logic [AW-1:0] start_b;
  logic [EW-1:0] end_b;
  logic          in_np;
  logic          in_pf;
  logic          fits_line;

  always_comb begin
    start_b   = addr & ~AW'(3);
    end_b     = {1'b0, start_b} + (EW'(len_dw) << 2) - EW'(1);
    in_np     = (start_b >= np_base) && (end_b <= {1'b0, np_limit});
    in_pf     = (start_b >= pf_base) && (end_b <= {1'b0, pf_limit});
    fits_line = (32'(len_dw) <= 32'(cls_dw));
    hit       = in_np || in_pf;
    if (in_np)          cmd = CMD_MR;
    else if (fits_line) cmd = CMD_MRL;
    else                cmd = CMD_MRM;
  end

endmodule

// File: rtl/rdx_rr_pick.sv
module rdx_rr_pick #(
  parameter int NSLOT = 2,
  parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0] active,
  input  logic [SW-1:0]    last_ptr,
  output logic             gnt_valid,
  output logic [SW-1:0]    gnt_idx,
  output logic             free_valid,
  output logic [SW-1:0]    free_idx
);

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      automatic int c = (int'(last_ptr) + 1 + i) % NSLOT;
      if (!gnt_valid && active[c]) begin
        gnt_valid = 1'b1;
        gnt_idx   = SW'(c);
      end
    end
  end

  always_comb begin
    free_valid = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!free_valid && !active[i]) begin
        free_valid = 1'b1;
        free_idx   = SW'(i);
      end
    end
  end

endmodule

// File: rtl/rdx_slot_table.sv
module rdx_slot_table #(
  parameter int NSLOT = 2,
  parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  parameter int DWA   = 30,
  parameter int LW    = 11,
  parameter int TW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [SW-1:0]    alloc_idx,
  input  logic [DWA-1:0]   alloc_dwa,
  input  logic [LW-1:0]    alloc_len,
  input  logic [TW-1:0]    alloc_tag,
  input  logic [3:0]       alloc_cmd,
  input  logic [3:0]       alloc_fbe,
  input  logic [3:0]       alloc_lbe,
  input  logic             upd_en,
  input  logic [SW-1:0]    upd_idx,
  input  logic [LW-1:0]    upd_dw,
  input  logic             upd_done,
  output logic [NSLOT-1:0] active,
  output logic [NSLOT-1:0] first,
  output logic [DWA-1:0]   next_dwa  [NSLOT],
  output logic [DWA-1:0]   fbase_dwa [NSLOT],
  output logic [LW-1:0]    rem       [NSLOT],
  output logic [LW-1:0]    acc       [NSLOT],
  output logic [TW-1:0]    tag       [NSLOT],
  output logic [3:0]       cmd       [NSLOT],
  output logic [3:0]       fbe       [NSLOT],
  output logic [3:0]       lbe       [NSLOT]
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic           act_r, first_r;
    logic [DWA-1:0] next_r, fbase_r;
    logic [LW-1:0]  rem_r, acc_r;
    logic [TW-1:0]  tag_r;
    logic [3:0]     cmd_r, fbe_r, lbe_r;
    logic           sel_alloc, sel_upd;

    assign sel_alloc = alloc_en && (alloc_idx == SW'(s));
    assign sel_upd   = upd_en && (upd_idx == SW'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        act_r   <= 1'b0;
        first_r <= 1'b0;
        next_r  <= '0;
        fbase_r <= '0;
        rem_r   <= '0;
        acc_r   <= '0;
        tag_r   <= '0;
        cmd_r   <= '0;
        fbe_r   <= '0;
        lbe_r   <= '0;
      end else if (sel_alloc) begin
        act_r   <= 1'b1;
        first_r <= 1'b1;
        next_r  <= alloc_dwa;
        fbase_r <= alloc_dwa;
        rem_r   <= alloc_len;
        acc_r   <= '0;
        tag_r   <= alloc_tag;
        cmd_r   <= alloc_cmd;
        fbe_r   <= alloc_fbe;
        lbe_r   <= alloc_lbe;
      end else if (sel_upd) begin
        next_r <= next_r + DWA'(upd_dw);
        rem_r  <= rem_r - upd_dw;
        if (upd_dw != '0) first_r <= 1'b0;
        if (upd_done) begin
          fbase_r <= next_r + DWA'(upd_dw);
          acc_r   <= '0;
          if (rem_r == upd_dw) act_r <= 1'b0;
        end else begin
          acc_r <= acc_r + upd_dw;
        end
      end
    end

    assign active[s]    = act_r;
    assign first[s]     = first_r;
    assign next_dwa[s]  = next_r;
    assign fbase_dwa[s] = fbase_r;
    assign rem[s]       = rem_r;
    assign acc[s]       = acc_r;
    assign tag[s]       = tag_r;
    assign cmd[s]       = cmd_r;
    assign fbe[s]       = fbe_r;
    assign lbe[s]       = lbe_r;

    AST_SLOT_REM_NONZERO: assert property (@(posedge clk) disable iff (rst)
      act_r |-> rem_r != '0);  // R6
    AST_UPD_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
      sel_upd |-> upd_dw <= rem_r);  // R6
  end

  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !active[alloc_idx]);  // R10

endmodule

// File: rtl/rdx_rd_split.sv
module rdx_rd_split
  import rdx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 11,
  parameter int TW         = 8,
  parameter int CW         = 8,
  parameter int NSLOT      = 2,
  parameter int FRAG_BYTES = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [3:0]    req_fbe,
  input  logic [3:0]    req_lbe,
  input  logic [TW-1:0] req_tag,
  input  logic [AW-1:0] np_base,
  input  logic [AW-1:0] np_limit,
  input  logic [AW-1:0] pf_base,
  input  logic [AW-1:0] pf_limit,
  input  logic [CW-1:0] cls_dw,
  output logic          pci_valid,
  output logic [3:0]    pci_cmd,
  output logic [AW-1:0] pci_addr,
  output logic [LW-1:0] pci_len,
  output logic [3:0]    pci_be_first,
  output logic [3:0]    pci_be_last,
  output logic [TW-1:0] pci_tag,
  input  logic          st_valid,
  input  logic [1:0]    st_kind,
  input  logic [LW-1:0] st_dw,
  output logic          cpl_valid,
  output logic [TW-1:0] cpl_tag,
  output logic [AW-1:0] cpl_addr,
  output logic [LW-1:0] cpl_len,
  output logic          cpl_last,
  output logic          ur_valid,
  output logic [TW-1:0] ur_tag
);
  localparam int DWA     = AW - 2;
  localparam int FRAG_DW = FRAG_BYTES / 4;
  localparam int FB      = $clog2(FRAG_DW);
  localparam int SW      = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  // classification of the incoming request
  logic       cls_hit;
  logic [3:0] cls_cmd;

  rdx_classify #(.AW(AW), .LW(LW), .CW(CW)) u_cls (
    .addr(req_addr), .len_dw(req_len),
    .np_base(np_base), .np_limit(np_limit),
    .pf_base(pf_base), .pf_limit(pf_limit),
    .cls_dw(cls_dw), .hit(cls_hit), .cmd(cls_cmd)
  );

  // slot table
  logic [NSLOT-1:0] t_act, t_first;
  logic [DWA-1:0]   t_next  [NSLOT];
  logic [DWA-1:0]   t_fbase [NSLOT];
  logic [LW-1:0]    t_rem   [NSLOT];
  logic [LW-1:0]    t_acc   [NSLOT];
  logic [TW-1:0]    t_tag   [NSLOT];
  logic [3:0]       t_cmd   [NSLOT];
  logic [3:0]       t_fbe   [NSLOT];
  logic [3:0]       t_lbe   [NSLOT];

  logic          gnt_valid, free_valid;
  logic [SW-1:0] gnt_idx, free_idx, last_ptr, cur_slot;
  logic          accept, alloc_en, upd_en, upd_done;
  logic [LW-1:0] upd_dw;

  rdx_rr_pick #(.NSLOT(NSLOT), .SW(SW)) u_pick (
    .active(t_act), .last_ptr(last_ptr),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
    .free_valid(free_valid), .free_idx(free_idx)
  );

  assign req_ready = free_valid;
  assign accept    = req_valid && req_ready;
  assign alloc_en  = accept && cls_hit;
  assign upd_en    = st_valid && pci_valid;
  assign upd_done  = (st_kind == ST_DONE);

  always_comb begin
    if (st_kind == ST_DONE)      upd_dw = pci_len;
    else if (st_kind == ST_DISC) upd_dw = st_dw;
    else                         upd_dw = '0;
  end

  rdx_slot_table #(.NSLOT(NSLOT), .SW(SW), .DWA(DWA), .LW(LW), .TW(TW)) u_tab (
    .clk(clk), .rst(rst),
    .alloc_en(alloc_en), .alloc_idx(free_idx),
    .alloc_dwa(req_addr[AW-1:2]), .alloc_len(req_len), .alloc_tag(req_tag),
    .alloc_cmd(cls_cmd), .alloc_fbe(req_fbe), .alloc_lbe(req_lbe),
    .upd_en(upd_en), .upd_idx(cur_slot), .upd_dw(upd_dw), .upd_done(upd_done),
    .active(t_act), .first(t_first),
    .next_dwa(t_next), .fbase_dwa(t_fbase), .rem(t_rem), .acc(t_acc),
    .tag(t_tag), .cmd(t_cmd), .fbe(t_fbe), .lbe(t_lbe)
  );

  // next attempt for the granted slot
  logic [LW-1:0] to_bnd, att_len;
  logic [3:0]    be_head, be_tail;
  logic          g_single, g_ends;

  always_comb begin
    to_bnd   = LW'(FRAG_DW) - LW'(t_next[gnt_idx][FB-1:0]);
    att_len  = (t_rem[gnt_idx] < to_bnd) ? t_rem[gnt_idx] : to_bnd;
    g_single = t_first[gnt_idx] && (t_rem[gnt_idx] == LW'(1));
    g_ends   = (att_len == t_rem[gnt_idx]);
    if (t_first[gnt_idx])              be_head = t_fbe[gnt_idx];
    else if (t_rem[gnt_idx] == LW'(1)) be_head = t_lbe[gnt_idx];
    else                               be_head = 4'hF;
    if (att_len == LW'(1))             be_tail = be_head;
    else if (g_ends)                   be_tail = g_single ? t_fbe[gnt_idx] : t_lbe[gnt_idx];
    else                               be_tail = 4'hF;
  end

  // attempt register
  always_ff @(posedge clk) begin
    if (rst) begin
      pci_valid    <= 1'b0;
      pci_cmd      <= '0;
      pci_addr     <= '0;
      pci_len      <= '0;
      pci_be_first <= '0;
      pci_be_last  <= '0;
      pci_tag      <= '0;
      cur_slot     <= '0;
      last_ptr     <= SW'(NSLOT - 1);
    end else if (upd_en) begin
      pci_valid <= 1'b0;
    end else if (!pci_valid && gnt_valid) begin
      pci_valid    <= 1'b1;
      pci_cmd      <= t_cmd[gnt_idx];
      pci_addr     <= {t_next[gnt_idx], 2'b00};
      pci_len      <= att_len;
      pci_be_first <= be_head;
      pci_be_last  <= be_tail;
      pci_tag      <= t_tag[gnt_idx];
      cur_slot     <= gnt_idx;
      last_ptr     <= gnt_idx;
    end
  end

  // completion fragment and unsupported strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
      cpl_addr  <= '0;
      cpl_len   <= '0;
      cpl_last  <= 1'b0;
      ur_valid  <= 1'b0;
      ur_tag    <= '0;
    end else begin
      cpl_valid <= upd_en && upd_done;
      if (upd_en && upd_done) begin
        cpl_tag  <= t_tag[cur_slot];
        cpl_addr <= {t_fbase[cur_slot], 2'b00};
        cpl_len  <= t_acc[cur_slot] + pci_len;
        cpl_last <= (t_rem[cur_slot] == pci_len);
      end
      ur_valid <= accept && !cls_hit;
      if (accept && !cls_hit) ur_tag <= req_tag;
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    pci_valid |-> (pci_cmd == CMD_MR || pci_cmd == CMD_MRL || pci_cmd == CMD_MRM));  // R1
  AST_ATT_IN_FRAG: assert property (@(posedge clk) disable iff (rst)
    pci_valid |-> (LW'(pci_addr[FB+1:2]) + pci_len) <= LW'(FRAG_DW));  // R5
  AST_NO_OVERREAD: assert property (@(posedge clk) disable iff (rst)
    pci_valid |-> (pci_len != '0) && (pci_len <= t_rem[cur_slot]));  // R6
  AST_STATUS_IN_ATTEMPT: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> pci_valid);  // R8
  AST_ATT_HELD: assert property (@(posedge clk) disable iff (rst)
    pci_valid && !st_valid |=> pci_valid && $stable(pci_addr) && $stable(pci_len) && $stable(pci_cmd));  // R8
  AST_CPL_BOUND: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> (cpl_len != '0) && (cpl_len <= LW'(FRAG_DW)));  // R9
  AST_CPL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> $past(st_valid) && ($past(st_kind) == ST_DONE));  // R9
  AST_UR_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
    accept && !cls_hit |=> $stable(t_act));  // R4

endmodule

// File: tb/sim_rdx_rd_split.sv
`timescale 1ns/1ps
module sim_rdx_rd_split;
  localparam int AW = 32, LW = 11, TW = 8, CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [3:0]    req_fbe, req_lbe;
  logic [TW-1:0] req_tag;
  logic [AW-1:0] np_base, np_limit, pf_base, pf_limit;
  logic [CW-1:0] cls_dw;
  logic          pci_valid;
  logic [3:0]    pci_cmd;
  logic [AW-1:0] pci_addr;
  logic [LW-1:0] pci_len;
  logic [3:0]    pci_be_first, pci_be_last;
  logic [TW-1:0] pci_tag;
  logic          st_valid;
  logic [1:0]    st_kind;
  logic [LW-1:0] st_dw;
  logic          cpl_valid;
  logic [TW-1:0] cpl_tag;
  logic [AW-1:0] cpl_addr;
  logic [LW-1:0] cpl_len;
  logic          cpl_last;
  logic          ur_valid;
  logic [TW-1:0] ur_tag;

  int nchk = 0;
  int nbad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  rdx_rd_split u0 (.*);

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send_req(logic [AW-1:0] a, int len, logic [3:0] fb, logic [3:0] lb, logic [TW-1:0] t);
    @(negedge clk);
    req_addr = a; req_len = LW'(len); req_fbe = fb; req_lbe = lb; req_tag = t;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_att(output bit got);
    got = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (pci_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_att(string r, logic [3:0] cmd, logic [AW-1:0] a, int len,
                            logic [3:0] bf, logic [3:0] bl, logic [TW-1:0] t);
    bit got;
    wait_att(got);
    chk({r, " attempt present"}, 64'(got), 64'(1));
    chk({r, " cmd"}, 64'(pci_cmd), 64'(cmd));
    chk({r, " addr"}, 64'(pci_addr), 64'(a));
    chk({r, " len"}, 64'(pci_len), 64'(len));
    chk({r, " be_first"}, 64'(pci_be_first), 64'(bf));
    chk({r, " be_last"}, 64'(pci_be_last), 64'(bl));
    chk({r, " tag"}, 64'(pci_tag), 64'(t));
  endtask

  // drive one status at the current negedge; cpl outputs are sampled at the next negedge
  task automatic status(logic [1:0] k, int dw);
    st_valid = 1'b1; st_kind = k; st_dw = LW'(dw);
    @(negedge clk);
    st_valid = 1'b0; st_kind = 2'd0; st_dw = '0;
  endtask

  task automatic expect_cpl(string r, logic [TW-1:0] t, logic [AW-1:0] a, int len, bit last);
    chk({r, " cpl_valid"}, 64'(cpl_valid), 64'(1));
    chk({r, " cpl_tag"}, 64'(cpl_tag), 64'(t));
    chk({r, " cpl_addr"}, 64'(cpl_addr), 64'(a));
    chk({r, " cpl_len"}, 64'(cpl_len), 64'(len));
    chk({r, " cpl_last"}, 64'(cpl_last), 64'(last));
  endtask

  task automatic t_reset;
    chk("R11 pci_valid", 64'(pci_valid), 64'(0));
    chk("R11 cpl_valid", 64'(cpl_valid), 64'(0));
    chk("R11 ur_valid", 64'(ur_valid), 64'(0));
    chk("R11 req_ready", 64'(req_ready), 64'(1));
  endtask

  task automatic t_nonprefetch;
    send_req(32'h1000_0010, 4, 4'hE, 4'h7, 8'h11);
    expect_att("R1 R7", 4'b0110, 32'h1000_0010, 4, 4'hE, 4'h7, 8'h11);
    status(2'd0, 0);
    expect_cpl("R9", 8'h11, 32'h1000_0010, 4, 1'b1);
  endtask

  task automatic t_single_dw;
    send_req(32'h1000_0104, 1, 4'h3, 4'h0, 8'h12);
    expect_att("R7 single", 4'b0110, 32'h1000_0104, 1, 4'h3, 4'h3, 8'h12);
    status(2'd0, 0);
    expect_cpl("R7 single", 8'h12, 32'h1000_0104, 1, 1'b1);
  endtask

  task automatic t_line_vs_multiple;
    send_req(32'h2000_0400, 8, 4'hF, 4'hF, 8'h21);
    expect_att("R2 equal", 4'b1110, 32'h2000_0400, 8, 4'hF, 4'hF, 8'h21);
    status(2'd0, 0);
    send_req(32'h2000_0400, 5, 4'hF, 4'hF, 8'h22);
    expect_att("R2 below", 4'b1110, 32'h2000_0400, 5, 4'hF, 4'hF, 8'h22);
    status(2'd0, 0);
    send_req(32'h2000_0400, 9, 4'hF, 4'hF, 8'h23);
    expect_att("R3", 4'b1100, 32'h2000_0400, 9, 4'hF, 4'hF, 8'h23);
    status(2'd0, 0);
    expect_cpl("R3", 8'h23, 32'h2000_0400, 9, 1'b1);
  endtask

  task automatic t_unsupported;
    send_req(32'h3000_0000, 4, 4'hF, 4'hF, 8'h09);
    chk("R4 ur_valid", 64'(ur_valid), 64'(1));
    chk("R4 ur_tag", 64'(ur_tag), 64'(8'h09));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R4 no attempt", 64'(pci_valid), 64'(0));
    end
    chk("R4 ur pulse ends", 64'(ur_valid), 64'(0));
    chk("R4 slot not used", 64'(req_ready), 64'(1));
    // range runs past the prefetchable limit
    send_req(32'h2000_FFF8, 4, 4'hF, 4'hF, 8'h0A);
    chk("R4 straddle ur_valid", 64'(ur_valid), 64'(1));
    chk("R4 straddle ur_tag", 64'(ur_tag), 64'(8'h0A));
    @(negedge clk);
    @(negedge clk);
    chk("R4 straddle no attempt", 64'(pci_valid), 64'(0));
  endtask

  task automatic t_split;
    send_req(32'h2000_0070, 40, 4'hC, 4'h3, 8'h05);
    expect_att("R5 head", 4'b1100, 32'h2000_0070, 4, 4'hC, 4'hF, 8'h05);
    status(2'd0, 0);
    expect_cpl("R9 head", 8'h05, 32'h2000_0070, 4, 1'b0);
    expect_att("R5 R6 middle", 4'b1100, 32'h2000_0080, 32, 4'hF, 4'hF, 8'h05);
    status(2'd0, 0);
    expect_cpl("R9 middle", 8'h05, 32'h2000_0080, 32, 1'b0);
    expect_att("R6 R7 tail", 4'b1100, 32'h2000_0100, 4, 4'hF, 4'h3, 8'h05);
    status(2'd0, 0);
    expect_cpl("R9 tail", 8'h05, 32'h2000_0100, 4, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 nothing past end", 64'(pci_valid), 64'(0));
    end
  endtask

  task automatic t_retry_disconnect;
    send_req(32'h2000_0200, 16, 4'hF, 4'hF, 8'h07);
    expect_att("R8 first", 4'b1100, 32'h2000_0200, 16, 4'hF, 4'hF, 8'h07);
    status(2'd1, 0);
    chk("R8 retry no cpl", 64'(cpl_valid), 64'(0));
    expect_att("R8 after retry", 4'b1100, 32'h2000_0200, 16, 4'hF, 4'hF, 8'h07);
    status(2'd2, 6);
    chk("R8 disc no cpl", 64'(cpl_valid), 64'(0));
    expect_att("R8 after disc", 4'b1100, 32'h2000_0218, 10, 4'hF, 4'hF, 8'h07);
    status(2'd0, 0);
    expect_cpl("R8 R9 merged", 8'h07, 32'h2000_0200, 16, 1'b1);
  endtask

  task automatic t_two_outstanding;
    send_req(32'h1000_0020, 2, 4'hF, 4'hF, 8'h01);
    expect_att("R10 A", 4'b0110, 32'h1000_0020, 2, 4'hF, 4'hF, 8'h01);
    send_req(32'h2000_0040, 2, 4'hF, 4'hF, 8'h02);
    chk("R10 ready low when full", 64'(req_ready), 64'(0));
    status(2'd1, 0);
    expect_att("R10 rotate to B", 4'b1110, 32'h2000_0040, 2, 4'hF, 4'hF, 8'h02);
    status(2'd0, 0);
    expect_cpl("R10 B", 8'h02, 32'h2000_0040, 2, 1'b1);
    expect_att("R10 back to A", 4'b0110, 32'h1000_0020, 2, 4'hF, 4'hF, 8'h01);
    status(2'd0, 0);
    expect_cpl("R10 A", 8'h01, 32'h1000_0020, 2, 1'b1);
    @(negedge clk);
    chk("R10 ready after drain", 64'(req_ready), 64'(1));
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_addr = '0; req_len = '0; req_fbe = '0; req_lbe = '0; req_tag = '0;
    st_valid = 1'b0; st_kind = '0; st_dw = '0;
    np_base = 32'h1000_0000; np_limit = 32'h1000_FFFF;
    pf_base = 32'h2000_0000; pf_limit = 32'h2000_FFFF;
    cls_dw = 8'd8;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nonprefetch();
    t_single_dw();
    t_line_vs_multiple();
    t_unsupported();
    t_split();
    t_retry_disconnect();
    t_two_outstanding();
    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule